// File: doc/BRIEF.md
# Flash card register window unit

This block is the register file on the card side of a legacy serial flash card. The host first opens two access windows, one for reads and one for writes, each a start offset plus a length. It then writes the parameter registers (system setup, block address, access mode, page address, redundant-area flags, logical address), issues a command, and reads the interrupt and status registers back. Any register access outside the window for its direction is dropped: a write changes nothing and a read returns 0xFF.

The flash array, the error-correction engine and the serial line are not modelled here. Other logic drives them in as single-cycle strobes (command issue, page transferred, operation finished) and as level inputs (error flags, write protect, buffer state, busy). The page-address register steps during a multi-page transfer as the access mode selects. After such a transfer it holds the last page touched, so the host can read back how far the transfer went.

Top module: `fcard_regwin`

## Requirements
- R1: After reset the registers read as: interrupt 0x00, system 0x80, block address 0x000000, access mode 0x00, page 0x00, overwrite flag 0xFF, management flag 0xFF, logical address 0xFFFF. Both windows reset closed, with a length of 0.
- R2: A read hits when start <= addr < start + len. `win_set` loads all four window values, and a length of 0 closes that window. A read that misses returns 0xFF.
- R3: A write whose address is outside the write window leaves every register unchanged.
- R4: Register offsets are: 0x00 interrupt, 0x01 status0, 0x02 status1, 0x03 system, 0x04/0x05/0x06 block address (high, middle, low byte), 0x07 access mode, 0x08 page, 0x09 overwrite flag, 0x0A management flag, 0x0B/0x0C logical address (high, low). Every register reads back. Writes to 0x00 through 0x02 are ignored, and unmapped offsets read 0xFF.
- R5: System bit 7 always reads 1. System bit 3 drives `par_mode` (1 = parallel, 0 = serial).
- R6: Status0 shows the inputs live: bit 0 write protect, bit 4 buffer full, bit 5 buffer empty, bit 6 flash busy, bit 7 media busy. Status1 bits 6 and 7 repeat flash busy and media busy.
- R7: On `page_done`, the page register increments only when the access mode has bits 7:5 all zero (data plus extra, auto-increment). With bit 5 set (data plus extra), bit 6 set (extra only) or bit 7 set (overwrite flag only), it holds.
- R8: A `page_done` that has `page_last` set never advances the page, so after a multi-page transfer the register holds the last page accessed.
- R9: An accepted command (`cmd_start` while media is not busy) clears interrupt bits 7 (ended), 6 (error), 5 (block ready) and 0 (refused), and also clears the status1 error bits 5:0. While the command runs, `page_done` sets interrupt bit 5.
- R10: `flash_done` during a command sets interrupt bit 7 and clears bit 5. It latches `err_flags` into status1 bits 5:0 and sets interrupt bit 6 when any of those flags is 1.
- R11: `cmd_start` while media is busy is refused: the interrupt register becomes 0x81.
- R12: Read data and `rd_valid` appear on the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_set | input | 1 | Load both windows |
| rd_win_start | input | AW | Read window start offset |
| rd_win_len | input | AW | Read window length |
| wr_win_start | input | AW | Write window start offset |
| wr_win_len | input | AW | Write window length |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write offset |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Read offset |
| rd_data | output | 8 | Read data, one cycle after the strobe |
| rd_valid | output | 1 | Read data valid |
| cmd_start | input | 1 | Host command issued |
| page_done | input | 1 | One page transferred |
| page_last | input | 1 | Qualifies `page_done` as the final page |
| flash_done | input | 1 | Flash operation finished |
| err_flags | input | 6 | Error flags that `flash_done` latches into status1 |
| wp_in | input | 1 | Write protected |
| buf_full_in | input | 1 | Buffer full (read direction) |
| buf_empty_in | input | 1 | Buffer empty (write direction) |
| flash_busy_in | input | 1 | Flash busy |
| media_busy_in | input | 1 | Media busy |
| par_mode | output | 1 | Parallel mode selected |

## Verification
The bench sets up narrow read and write windows to check the edges of a window: the offset one below the start, the start itself, and the offset one past the end. An off-by-one compare would either leak a register value or drop a legal access. It runs a three-page transfer in the auto-increment mode and ends it with a flagged final page. The page must land on the last page accessed and not one beyond it. Each of the three hold modes then gets a page strobe, so a design that still increments there reads a wrong page. A command is finished with error flags to check that the error bit and the status1 latch are set, and a following command must clear both. A command issued while the media is busy must come back refused, not started.

// File: rtl/fcard_pkg.sv
`timescale 1ns/1ps
package fcard_pkg;

    localparam int DW = 8;

    // register offsets
    localparam int A_INTR = 0;
    localparam int A_ST0  = 1;
    localparam int A_ST1  = 2;
    localparam int A_SYS  = 3;
    localparam int A_BLKH = 4;
    localparam int A_BLKM = 5;
    localparam int A_BLKL = 6;
    localparam int A_MODE = 7;
    localparam int A_PAGE = 8;
    localparam int A_OVW  = 9;
    localparam int A_MGMT = 10;
    localparam int A_LBAH = 11;
    localparam int A_LBAL = 12;

    // interrupt bit positions
    localparam int I_CED  = 7;
    localparam int I_ERR  = 6;
    localparam int I_BREQ = 5;
    localparam int I_NAK  = 0;

    localparam int SYS_PAR = 3;
    localparam int SYS_FIX = 7;

    typedef enum logic [1:0] {
        XF_BLOCK,
        XF_PAGE,
        XF_EXTRA,
        XF_FLAG
    } xfer_e;

    typedef struct packed {
        logic [DW-1:0]   sys;
        logic [3*DW-1:0] blk;
        logic [DW-1:0]   mode;
        logic [DW-1:0]   ovw;
        logic [DW-1:0]   mgmt;
        logic [2*DW-1:0] lba;
    } cfg_t;

    function automatic xfer_e decode_mode(input logic [DW-1:0] m);
        if (m[7])      return XF_FLAG;
        else if (m[6]) return XF_EXTRA;
        else if (m[5]) return XF_PAGE;
        else           return XF_BLOCK;
    endfunction

endpackage

// File: rtl/fcard_win_dec.sv
`timescale 1ns/1ps
module fcard_win_dec #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] start,
    input  logic [AW-1:0] len,
    output logic          hit
);
    localparam int EW = AW + 1;

    logic [EW-1:0] a_ext;
    logic [EW-1:0] lo_ext;
    logic [EW-1:0] hi_ext;

    always_comb begin
        a_ext  = {1'b0, addr};
        lo_ext = {1'b0, start};
        hi_ext = lo_ext + {1'b0, len};
        hit    = (a_ext >= lo_ext) && (a_ext < hi_ext);
    end
endmodule

// File: rtl/fcard_page_step.sv
`timescale 1ns/1ps
module fcard_page_step
    import fcard_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic [PW-1:0] page_q,
    input  logic [DW-1:0] mode,
    input  logic          page_done,
    input  logic          page_last,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    output logic [PW-1:0] page_d
);
    xfer_e kind;

    always_comb begin
        kind   = decode_mode(mode);
        page_d = page_q;
        if (load) begin
            page_d = load_val;
        end else if (page_done && !page_last && kind == XF_BLOCK) begin
            page_d = page_q + PW'(1);
        end
    end
endmodule

// File: rtl/fcard_irq_unit.sv
`timescale 1ns/1ps
module fcard_irq_unit
    import fcard_pkg::*;
#(
    parameter int EW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic          media_busy,
    input  logic          page_done,
    input  logic          flash_done,
    input  logic [EW-1:0] err_in,
    output logic [DW-1:0] intr_q,
    output logic [EW-1:0] err_q,
    output logic          active_q
);
    typedef struct packed {
        logic [DW-1:0] intr;
        logic [EW-1:0] err;
        logic          active;
    } irq_st_t;

    irq_st_t d, q;

    always_comb begin
        d = q;
        if (cmd_start) begin
            if (media_busy) begin
                d.intr         = '0;
                d.intr[I_CED]  = 1'b1;
                d.intr[I_NAK]  = 1'b1;
                d.active       = 1'b0;
            end else begin
                d.intr         = '0;
                d.err          = '0;
                d.active       = 1'b1;
            end
        end else if (q.active) begin
            if (page_done) begin
                d.intr[I_BREQ] = 1'b1;
            end
            if (flash_done) begin
                d.intr[I_CED]  = 1'b1;
                d.intr[I_ERR]  = |err_in;
                d.intr[I_BREQ] = 1'b0;
                d.err          = err_in;
                d.active       = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign intr_q   = q.intr;
    assign err_q    = q.err;
    assign active_q = q.active;
endmodule

// File: rtl/fcard_regwin.sv
`timescale 1ns/1ps
module fcard_regwin
    import fcard_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_set,
    input  logic [AW-1:0] rd_win_start,
    input  logic [AW-1:0] rd_win_len,
    input  logic [AW-1:0] wr_win_start,
    input  logic [AW-1:0] wr_win_len,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          rd_valid,
    input  logic          cmd_start,
    input  logic          page_done,
    input  logic          page_last,
    input  logic          flash_done,
    input  logic [5:0]    err_flags,
    input  logic          wp_in,
    input  logic          buf_full_in,
    input  logic          buf_empty_in,
    input  logic          flash_busy_in,
    input  logic          media_busy_in,
    output logic          par_mode
);
    localparam int EW = 6;

    typedef struct packed {
        logic [AW-1:0] rws;
        logic [AW-1:0] rwl;
        logic [AW-1:0] wws;
        logic [AW-1:0] wwl;
        cfg_t          cfg;
        logic [DW-1:0] page;
        logic [DW-1:0] rdat;
        logic          rvld;
    } st_t;

    st_t d, q;

    logic          rd_hit;
    logic          wr_win_hit;
    logic          wr_hit;
    logic          page_wr;
    logic [DW-1:0] page_nxt;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] st0;
    logic [DW-1:0] st1;
    logic [DW-1:0] intr_q;
    logic [EW-1:0] err_q;
    logic          active_q;
    logic [DW-1:0] mode_q;
    logic [DW-1:0] page_q;
    logic [AW-1:0] rd_ws_q;
    logic [AW-1:0] rd_wl_q;

    assign mode_q  = q.cfg.mode;
    assign page_q  = q.page;
    assign rd_ws_q = q.rws;
    assign rd_wl_q = q.rwl;

    fcard_win_dec #(.AW(AW)) u_rd_win (
        .addr  (rd_addr),
        .start (q.rws),
        .len   (q.rwl),
        .hit   (rd_hit)
    );

    fcard_win_dec #(.AW(AW)) u_wr_win (
        .addr  (wr_addr),
        .start (q.wws),
        .len   (q.wwl),
        .hit   (wr_win_hit)
    );

    assign wr_hit  = wr_en && wr_win_hit;
    assign page_wr = wr_hit && (int'(wr_addr) == A_PAGE);

    fcard_page_step #(.PW(DW)) u_page (
        .page_q    (q.page),
        .mode      (q.cfg.mode),
        .page_done (page_done),
        .page_last (page_last),
        .load      (page_wr),
        .load_val  (wr_data),
        .page_d    (page_nxt)
    );

    fcard_irq_unit #(.EW(EW)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .media_busy (media_busy_in),
        .page_done  (page_done),
        .flash_done (flash_done),
        .err_in     (err_flags),
        .intr_q     (intr_q),
        .err_q      (err_q),
        .active_q   (active_q)
    );

    // live status bytes
    always_comb begin
        st0    = '0;
        st0[0] = wp_in;
        st0[4] = buf_full_in;
        st0[5] = buf_empty_in;
        st0[6] = flash_busy_in;
        st0[7] = media_busy_in;
        st1    = {media_busy_in, flash_busy_in, err_q};
    end

    always_comb begin
        case (int'(rd_addr))
            A_INTR:  rd_mux = intr_q;
            A_ST0:   rd_mux = st0;
            A_ST1:   rd_mux = st1;
            A_SYS:   rd_mux = q.cfg.sys;
            A_BLKH:  rd_mux = q.cfg.blk[23:16];
            A_BLKM:  rd_mux = q.cfg.blk[15:8];
            A_BLKL:  rd_mux = q.cfg.blk[7:0];
            A_MODE:  rd_mux = q.cfg.mode;
            A_PAGE:  rd_mux = q.page;
            A_OVW:   rd_mux = q.cfg.ovw;
            A_MGMT:  rd_mux = q.cfg.mgmt;
            A_LBAH:  rd_mux = q.cfg.lba[15:8];
            A_LBAL:  rd_mux = q.cfg.lba[7:0];
            default: rd_mux = 8'hFF;
        endcase
    end

    always_comb begin
        d = q;
        if (win_set) begin
            d.rws = rd_win_start;
            d.rwl = rd_win_len;
            d.wws = wr_win_start;
            d.wwl = wr_win_len;
        end
        if (wr_hit) begin
            case (int'(wr_addr))
                A_SYS:   d.cfg.sys          = wr_data | 8'h80;
                A_BLKH:  d.cfg.blk[23:16]   = wr_data;
                A_BLKM:  d.cfg.blk[15:8]    = wr_data;
                A_BLKL:  d.cfg.blk[7:0]     = wr_data;
                A_MODE:  d.cfg.mode         = wr_data;
                A_OVW:   d.cfg.ovw          = wr_data;
                A_MGMT:  d.cfg.mgmt         = wr_data;
                A_LBAH:  d.cfg.lba[15:8]    = wr_data;
                A_LBAL:  d.cfg.lba[7:0]     = wr_data;
                default: ;
            endcase
        end
        d.page = page_nxt;
        d.rvld = rd_en;
        if (rd_en) begin
            d.rdat = rd_hit ? rd_mux : 8'hFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.cfg.sys  <= 8'h80;
            q.cfg.ovw  <= 8'hFF;
            q.cfg.mgmt <= 8'hFF;
            q.cfg.lba  <= 16'hFFFF;
        end else begin
            q <= d;
        end
    end

    assign rd_data  = q.rdat;
    assign rd_valid = q.rvld;
    assign par_mode = q.cfg.sys[SYS_PAR];

endmodule

// File: rtl/fcard_regwin_sva.sv
`timescale 1ns/1ps
module fcard_regwin_sva
    import fcard_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          rd_valid,
    input logic [7:0]    rd_data,
    input logic [AW-1:0] rd_ws_q,
    input logic [AW-1:0] rd_wl_q,
    input logic          cmd_start,
    input logic          media_busy_in,
    input logic          page_done,
    input logic          flash_done,
    input logic [5:0]    err_flags,
    input logic          active_q,
    input logic [7:0]    intr_q,
    input logic [7:0]    mode_q,
    input logic [7:0]    page_q,
    input logic          page_wr
);
    logic in_win;
    always_comb begin
        in_win = ({1'b0, rd_addr} >= {1'b0, rd_ws_q}) &&
                 ({1'b0, rd_addr} < ({1'b0, rd_ws_q} + {1'b0, rd_wl_q}));
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R12

    AST_MISS_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !in_win |=> rd_data == 8'hFF); // R2

    AST_SYS_MSB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && in_win && int'(rd_addr) == A_SYS |=> rd_data[SYS_FIX]); // R5

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        page_done && (mode_q[7:5] != 3'b000) && !page_wr |=> $stable(page_q)); // R7

    AST_CMD_CLEARS_END: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start && !media_busy_in |=> !intr_q[I_CED] && !intr_q[I_ERR]); // R9

    AST_DONE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        flash_done && active_q && !cmd_start && (|err_flags) |=> intr_q[I_CED] && intr_q[I_ERR]); // R10

    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start && media_busy_in |=> intr_q == 8'h81); // R11
endmodule

bind fcard_regwin fcard_regwin_sva #(.AW(AW)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .rd_ws_q       (rd_ws_q),
    .rd_wl_q       (rd_wl_q),
    .cmd_start     (cmd_start),
    .media_busy_in (media_busy_in),
    .page_done     (page_done),
    .flash_done    (flash_done),
    .err_flags     (err_flags),
    .active_q      (active_q),
    .intr_q        (intr_q),
    .mode_q        (mode_q),
    .page_q        (page_q),
    .page_wr       (page_wr)
);

// File: tb/fcard_regwin_tb.sv
`timescale 1ns/1ps
module fcard_regwin_tb;
    localparam int AW = 8;
    localparam int MAX_CYC = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          win_set = 1'b0;
    logic [AW-1:0] rd_win_start = '0, rd_win_len = '0;
    logic [AW-1:0] wr_win_start = '0, wr_win_len = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          rd_valid;
    logic          cmd_start = 1'b0, page_done = 1'b0, page_last = 1'b0, flash_done = 1'b0;
    logic [5:0]    err_flags = '0;
    logic          wp_in = 1'b0, buf_full_in = 1'b0, buf_empty_in = 1'b0;
    logic          flash_busy_in = 1'b0, media_busy_in = 1'b0;
    logic          par_mode;

    int checks = 0;
    int errors = 0;
    bit summary_done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    fcard_regwin #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .win_set(win_set),
        .rd_win_start(rd_win_start), .rd_win_len(rd_win_len),
        .wr_win_start(wr_win_start), .wr_win_len(wr_win_len),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .cmd_start(cmd_start), .page_done(page_done), .page_last(page_last),
        .flash_done(flash_done), .err_flags(err_flags),
        .wp_in(wp_in), .buf_full_in(buf_full_in), .buf_empty_in(buf_empty_in),
        .flash_busy_in(flash_busy_in), .media_busy_in(media_busy_in),
        .par_mode(par_mode)
    );

    // monitor: pops expectations as read data comes out
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R12: unexpected read data %02h, expected none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: read data %02h, expected %02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h, expected %02h", tag, act, exp);
        end
    endtask

    task automatic set_win(input int rs, input int rl, input int ws, input int wl);
        win_set = 1'b1;
        rd_win_start = AW'(rs); rd_win_len = AW'(rl);
        wr_win_start = AW'(ws); wr_win_len = AW'(wl);
        tick();
        win_set = 1'b0;
    endtask

    task automatic wr(input int a, input logic [7:0] v);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_en = 1'b1; rd_addr = AW'(a);
        tick();
        rd_en = 1'b0;
    endtask

    task automatic pulse_cmd();
        cmd_start = 1'b1; tick(); cmd_start = 1'b0;
    endtask

    task automatic pulse_page(input logic last);
        page_done = 1'b1; page_last = last; tick();
        page_done = 1'b0; page_last = 1'b0;
    endtask

    task automatic pulse_done(input logic [5:0] ef);
        flash_done = 1'b1; err_flags = ef; tick();
        flash_done = 1'b0; err_flags = '0;
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!summary_done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary_done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R2: windows closed at reset
        rd(3, 8'hFF, "R2 closed window");
        set_win(0, 16, 0, 16);

        // R1: reset values
        rd(0, 8'h00, "R1 intr");
        rd(3, 8'h80, "R1 sys");
        rd(4, 8'h00, "R1 blk hi");
        rd(7, 8'h00, "R1 mode");
        rd(8, 8'h00, "R1 page");
        rd(9, 8'hFF, "R1 ovw");
        rd(10, 8'hFF, "R1 mgmt");
        rd(11, 8'hFF, "R1 lba hi");
        rd(12, 8'hFF, "R1 lba lo");

        // R3 / R4: narrow write window 4..8
        set_win(0, 16, 4, 5);
        wr(10, 8'h12);
        wr(9, 8'h55);
        wr(3, 8'h08);
        wr(4, 8'h11);
        wr(5, 8'h22);
        wr(6, 8'h33);
        wr(8, 8'h07);
        rd(10, 8'hFF, "R3 mgmt outside");
        rd(9, 8'hFF, "R3 ovw one past end");
        rd(3, 8'h80, "R3 sys one below start");
        rd(4, 8'h11, "R4 blk hi at start");
        rd(5, 8'h22, "R4 blk mid");
        rd(6, 8'h33, "R4 blk lo");
        rd(8, 8'h07, "R4 page at end");
        set_win(0, 16, 0, 16);
        wr(9, 8'h7F);
        wr(11, 8'h01);
        wr(12, 8'hEE);
        wr(0, 8'hAA);
        rd(9, 8'h7F, "R4 ovw");
        rd(11, 8'h01, "R4 lba hi");
        rd(12, 8'hEE, "R4 lba lo");
        rd(0, 8'h00, "R4 intr read-only");
        rd(13, 8'hFF, "R4 unmapped");

        // R5
        wr(3, 8'h08);
        chk({7'd0, par_mode}, 8'h01, "R5 par_mode set");
        rd(3, 8'h88, "R5 sys parallel");
        wr(3, 8'h00);
        chk({7'd0, par_mode}, 8'h00, "R5 par_mode clear");
        rd(3, 8'h80, "R5 sys msb");

        // R6
        wp_in = 1'b1; flash_busy_in = 1'b1;
        rd(1, 8'h41, "R6 st0 wp+fb");
        rd(2, 8'h40, "R6 st1 fb");
        buf_full_in = 1'b1; media_busy_in = 1'b1;
        rd(1, 8'hD1, "R6 st0 all");
        rd(2, 8'hC0, "R6 st1 busy");
        wp_in = 1'b0; flash_busy_in = 1'b0; buf_full_in = 1'b0; media_busy_in = 1'b0;
        buf_empty_in = 1'b1;
        rd(1, 8'h20, "R6 st0 empty");
        buf_empty_in = 1'b0;

        // R2: partial read window 2..4
        set_win(2, 3, 0, 16);
        rd(1, 8'hFF, "R2 below start");
        rd(2, 8'h00, "R2 at start");
        rd(4, 8'h11, "R2 at end");
        rd(5, 8'hFF, "R2 one past end");
        set_win(0, 16, 0, 16);

        // R7/R8/R9/R10: auto-increment transfer
        wr(7, 8'h00);
        wr(8, 8'h03);
        pulse_cmd();
        rd(0, 8'h00, "R9 cmd clears intr");
        pulse_page(1'b0);
        rd(0, 8'h20, "R9 block ready");
        pulse_page(1'b0);
        pulse_page(1'b1);
        rd(8, 8'h05, "R8 last page held");
        pulse_done(6'h00);
        rd(0, 8'h80, "R10 clean end");
        rd(2, 8'h00, "R10 st1 clean");

        // R7: hold modes
        wr(7, 8'h20); pulse_page(1'b0);
        rd(8, 8'h05, "R7 page mode holds");
        wr(7, 8'h40); pulse_page(1'b0);
        rd(8, 8'h05, "R7 extra mode holds");
        wr(7, 8'h80); pulse_page(1'b0);
        rd(8, 8'h05, "R7 flag mode holds");
        wr(7, 8'h00); pulse_page(1'b0);
        rd(8, 8'h06, "R7 block mode steps");

        // R10 / R9: error completion then fresh command
        pulse_cmd();
        pulse_done(6'h30);
        rd(0, 8'hC0, "R10 error end");
        rd(2, 8'h30, "R10 st1 latched");
        pulse_cmd();
        rd(0, 8'h00, "R9 clears error");
        rd(2, 8'h00, "R9 clears st1");
        pulse_done(6'h00);
        rd(0, 8'h80, "R10 end after clear");

        // R11
        media_busy_in = 1'b1;
        pulse_cmd();
        media_busy_in = 1'b0;
        rd(0, 8'h81, "R11 refused");

        // R12: no stray data, queue drained
        tick(); tick();
        chk({7'd0, rd_valid}, 8'h00, "R12 idle valid low");
        chk(8'(exp_q.size()), 8'h00, "R12 all reads returned");

        summary_done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule